// File: doc/BRIEF.md
# Configurable Single-Port RAM

A one-port memory of `WORDS` entries, each `DATA_W` bits wide, addressed by an `ADDR_W`-bit bus. Writes take their timing from an input clock and reads are presented through an output clock. Three options are set at compile time and are independent of each other. The first decides whether the write data bus is captured on the input clock. The second decides whether writes are edge-triggered on the input clock or level-sensitive on the write enable. The third decides whether the read word is captured on the output clock or driven straight from the array.

Level-sensitive mode turns each word into a transparent latch that is open while the write enable is high and the address selects it. Address and data must therefore be steady while the enable is high. In edge-triggered mode, data and address are sampled at the same input clock edge, so the data-capture option has no visible effect there. The active-low asynchronous reset clears every word and the output register.

Top module: `sp_ram`

## Requirements
- R1: After reset, every in-range location reads as zero.
- R2: With edge-triggered writes (option value 1), a word changes only at a rising input clock edge where the write enable is high. The enable held high between edges writes nothing.
- R3: With level-sensitive writes (option value 0), the addressed word takes the write data while the enable is high, without any clock edge. It keeps following later data changes until the enable falls.
- R4: With captured write data and level-sensitive writes, the stored value is the data bus sampled at the latest rising input clock edge, not the live bus.
- R5: With uncaptured write data and level-sensitive writes, the live data bus is stored.
- R6: With a registered read (option value 1), the output changes only at a rising output clock edge. It then shows the word addressed at that edge.
- R7: With a combinational read (option value 0), the output follows an address change without waiting for a clock edge.
- R8: A write to an address at or above `WORDS` changes no word, and a read from such an address returns zero.
- R9: With edge-triggered writes and a registered read, a read at the same edge as a write to the same address returns the previous contents.
- R10: The registered read output is zero from reset until the first rising output clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in_i | input | 1 | Input clock: write data capture and edge-triggered writes |
| clk_out_i | input | 1 | Output clock: registered read |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write enable, active high |
| addr_i | input | ADDR_W | Word address for read and write |
| data_i | input | DATA_W | Write data |
| q_o | output | DATA_W | Read data |

## Verification
A read and a write to the same word can fall at one input clock edge. The bench holds the enable high on an address while the output clock samples that address. With edge-triggered writes and a registered read, the output must show the old word at that edge and the new word one edge later. A level write and a data-capture edge can also meet. The bench changes the data bus twice while the enable is high between edges. It then judges each configuration: the live last value, the earlier captured value, or no change.

// File: rtl/sp_ram_pkg.sv
`timescale 1ns/1ps
package sp_ram_pkg;
  // Per-stage choice: captured on a clock edge, or passed straight through.
  typedef enum bit {
    STAGE_UNREG = 1'b0,
    STAGE_REG   = 1'b1
  } stage_mode_e;
endpackage

// File: rtl/sp_ram_din_stage.sv
`timescale 1ns/1ps
module sp_ram_din_stage
  import sp_ram_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter stage_mode_e MODE   = STAGE_REG
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  if (MODE == STAGE_REG) begin : g_reg
    logic [DATA_W-1:0] hold_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hold_q <= '0;
      else         hold_q <= data_i;
    end
    assign data_o = hold_q;
  end else begin : g_pass
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign data_o = data_i;
  end
endmodule

// File: rtl/sp_ram_cells.sv
`timescale 1ns/1ps
module sp_ram_cells
  import sp_ram_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned WORDS  = 16,
  parameter stage_mode_e MODE   = STAGE_REG
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W:0] WORDS_L = (ADDR_W+1)'(WORDS);

  logic [WORDS-1:0][DATA_W-1:0] mem_flat;
  logic in_range;
  assign in_range = {1'b0, addr_i} < WORDS_L;

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(g);
    logic              hit;
    logic [DATA_W-1:0] word_q;
    assign hit = wr_en_i && (addr_i == IDX);
    if (MODE == STAGE_REG) begin : g_edge
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  word_q <= '0;
        else if (hit) word_q <= wdata_i;
      end
    end else begin : g_level
      // transparent while selected and enabled
      always_latch begin
        if (!rst_ni)  word_q <= '0;
        else if (hit) word_q <= wdata_i;
      end
    end
    assign mem_flat[g] = word_q;
  end

  // out-of-range addresses match no word and read as zero
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < WORDS; i++) begin
      if (addr_i == ADDR_W'(i)) rdata_o = mem_flat[i];
    end
  end

  if (MODE == STAGE_REG) begin : g_chk
    assert_idle_no_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i |=> $stable(mem_flat));
    assert_write_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && in_range) |=> mem_flat[$past(addr_i)] == $past(wdata_i));
    assert_oob_write_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !in_range) |=> $stable(mem_flat));
  end else begin : g_nochk
    logic unused_clk;
    assign unused_clk = clk_i ^ in_range;
  end
endmodule

// File: rtl/sp_ram_dout_stage.sv
`timescale 1ns/1ps
module sp_ram_dout_stage
  import sp_ram_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter stage_mode_e MODE   = STAGE_REG
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] q_o
);
  if (MODE == STAGE_REG) begin : g_reg
    logic [DATA_W-1:0] q_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_q <= '0;
      else         q_q <= rdata_i;
    end
    assign q_o = q_q;
  end else begin : g_pass
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign q_o = rdata_i;
  end
endmodule

// File: rtl/sp_ram.sv
`timescale 1ns/1ps
module sp_ram
  import sp_ram_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned WORDS    = 2**ADDR_W,
  parameter stage_mode_e DIN_MODE = STAGE_REG,
  parameter stage_mode_e WR_MODE  = STAGE_REG,
  parameter stage_mode_e RD_MODE  = STAGE_REG
) (
  input  logic              clk_in_i,
  input  logic              clk_out_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] q_o
);
  localparam logic [ADDR_W:0] WORDS_L = (ADDR_W+1)'(WORDS);
  // edge writes already sample data at the write edge; capture only for level writes
  localparam stage_mode_e DIN_EFF =
    (DIN_MODE == STAGE_REG && WR_MODE == STAGE_UNREG) ? STAGE_REG : STAGE_UNREG;

  if (WORDS < 1 || WORDS > 2**ADDR_W) begin : g_bad_cfg
    $error("sp_ram: WORDS out of range for ADDR_W");
  end

  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;
  logic              in_range;
  assign in_range = {1'b0, addr_i} < WORDS_L;

  sp_ram_din_stage #(.DATA_W(DATA_W), .MODE(DIN_EFF)) u_din (
    .clk_i (clk_in_i),
    .rst_ni(rst_ni),
    .data_i(data_i),
    .data_o(wdata)
  );

  sp_ram_cells #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WORDS(WORDS), .MODE(WR_MODE)) u_cells (
    .clk_i  (clk_in_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_en_i),
    .addr_i (addr_i),
    .wdata_i(wdata),
    .rdata_o(rdata)
  );

  sp_ram_dout_stage #(.DATA_W(DATA_W), .MODE(RD_MODE)) u_dout (
    .clk_i  (clk_out_i),
    .rst_ni (rst_ni),
    .rdata_i(rdata),
    .q_o    (q_o)
  );

  if (RD_MODE == STAGE_REG) begin : g_chk_reg
    assert_oob_read_zero_R8: assert property (@(posedge clk_out_i) disable iff (!rst_ni)
      !in_range |=> q_o == '0);
  end else begin : g_chk_comb
    assert_oob_read_zero_comb_R8: assert property (@(posedge clk_in_i) disable iff (!rst_ni)
      !in_range |-> q_o == '0);
  end
endmodule

// File: tb/sp_ram_test.sv
`timescale 1ns/1ps
module sp_ram_test;
  import sp_ram_pkg::*;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int NW = 6;
  localparam int NC = 8;  // config bit0 data capture, bit1 edge write, bit2 registered read

  logic clk_in = 1'b0, clk_out = 1'b0, rst_ni = 1'b0;
  logic we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic [DW-1:0] q_w [NC];
  logic [DW-1:0] em  [NC][NW];
  int n_chk = 0, n_bad = 0;

  always #5 clk_in  = ~clk_in;
  always #5 clk_out = ~clk_out;

  for (genvar c = 0; c < NC; c++) begin : g_cfg
    sp_ram #(
      .DATA_W(DW), .ADDR_W(AW), .WORDS(NW),
      .DIN_MODE(stage_mode_e'((c >> 0) & 1)),
      .WR_MODE (stage_mode_e'((c >> 1) & 1)),
      .RD_MODE (stage_mode_e'((c >> 2) & 1))
    ) uut (
      .clk_in_i(clk_in), .clk_out_i(clk_out), .rst_ni(rst_ni),
      .wr_en_i(we), .addr_i(addr), .data_i(data), .q_o(q_w[c])
    );
  end

  function automatic bit cap(int c);  return (c & 1) != 0; endfunction
  function automatic bit edg(int c);  return (c & 2) != 0; endfunction
  function automatic bit rreg(int c); return (c & 4) != 0; endfunction

  task automatic chk(input string req, input int c, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s cfg%0d addr=%0d got=%h exp=%h", req, c, addr, got, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic write_word(input int a, input logic [DW-1:0] d);
    @(posedge clk_in); #1 addr = AW'(a); data = d; we = 1'b1;
    @(posedge clk_in); #1 we = 1'b0;
    if (a < NW) for (int c = 0; c < NC; c++) em[c][a] = d;
  endtask

  task automatic read_all(input string req);
    for (int a = 0; a < NW; a++) begin
      @(posedge clk_in); #1 addr = AW'(a);
      @(posedge clk_in); #4;
      for (int c = 0; c < NC; c++) chk(req, c, q_w[c], em[c][a]);
    end
  endtask

  task automatic test_reset();
    for (int c = 0; c < NC; c++) for (int a = 0; a < NW; a++) em[c][a] = '0;
    #1 for (int c = 0; c < NC; c++) chk("R10", c, q_w[c], '0);
    #6 rst_ni = 1'b1;  // t=7, first edge at 15
    #1 for (int c = 0; c < NC; c++) if (rreg(c)) chk("R10", c, q_w[c], '0);
    read_all("R1");
  endtask

  task automatic test_fill();
    for (int a = 0; a < NW; a++) write_word(a, DW'(8'hA0 + a * 8'h13));
    read_all("R5");
  endtask

  task automatic test_oob();
    write_word(6, 8'hEE);
    write_word(7, 8'h77);
    read_all("R8");
    @(posedge clk_in); #1 addr = 3'd6;
    @(posedge clk_in); #4 for (int c = 0; c < NC; c++) chk("R8", c, q_w[c], '0);
    @(posedge clk_in); #1 addr = 3'd7;
    @(posedge clk_in); #4 for (int c = 0; c < NC; c++) chk("R8", c, q_w[c], '0);
  endtask

  task automatic test_out_timing();
    @(posedge clk_in); #1 addr = 3'd0;
    @(posedge clk_in); #1 addr = 3'd3;
    #2 for (int c = 0; c < NC; c++)
      chk(rreg(c) ? "R6" : "R7", c, q_w[c], rreg(c) ? em[c][0] : em[c][3]);
    @(posedge clk_out); #4 for (int c = 0; c < NC; c++) chk("R6", c, q_w[c], em[c][3]);
  endtask

  task automatic test_rdw();
    logic [DW-1:0] old_v;
    old_v = em[0][2];
    @(posedge clk_in); #1 addr = 3'd2; data = 8'h5A; we = 1'b1;
    @(posedge clk_in); #4;
    for (int c = 0; c < NC; c++) begin
      if (edg(c) && rreg(c))       chk("R9", c, q_w[c], old_v);
      else if (edg(c))             chk("R2", c, q_w[c], 8'h5A);
      else if (!cap(c))            chk("R3", c, q_w[c], 8'h5A);
    end
    @(posedge clk_in); #1 we = 1'b0;
    for (int c = 0; c < NC; c++) em[c][2] = 8'h5A;
    @(posedge clk_in); #4 for (int c = 0; c < NC; c++) chk("R9", c, q_w[c], 8'h5A);
  endtask

  task automatic test_level();
    logic [DW-1:0] old_v;
    old_v = em[0][4];
    @(posedge clk_in); #1 addr = 3'd4; data = 8'h3C; we = 1'b0;
    @(posedge clk_in); #1 data = 8'hC3; we = 1'b1;
    #1 data = 8'h99;
    #1 for (int c = 0; c < NC; c++) if (!rreg(c)) begin
      if (edg(c))      chk("R2", c, q_w[c], old_v);
      else if (cap(c)) chk("R4", c, q_w[c], 8'h3C);
      else             chk("R3", c, q_w[c], 8'h99);
    end
    #1 we = 1'b0;  // before the next input edge
    for (int c = 0; c < NC; c++) if (!edg(c)) em[c][4] = cap(c) ? 8'h3C : 8'h99;
    read_all("R4");
    write_word(4, 8'h44);
    read_all("R2");
  endtask

  initial begin
    test_reset();
    test_fill();
    test_oob();
    test_out_timing();
    test_rdw();
    test_level();
    summary();
    $finish;
  end

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end
endmodule